// File: doc/BRIEF.md
# Configuration Buffer Ownership Arbiter

This block decides who may use a single-port buffer RAM that holds a configuration image. The host side has two windows: a 16-byte register range (four 32-bit words) and a 1 MiB memory window that lands on the buffer RAM. While no load is running, the host owns the RAM. It writes the image as 32-bit words at increasing offsets and can read them back to compare.

When the host sets the start bit, the RAM address, data and enable paths switch to a configuration streamer. The `ram_stm_sel` output tells the RAM wrapper which clock to use. The streamer runs on its own clock. Start and done cross between the two clocks with two-flop synchronizers and a level handshake.

While the streamer owns the RAM, host memory traffic is intercepted and never reaches the RAM. The registers still answer. Once the streamer signals completion, the block clears the start bit. It hands the RAM back only after the streamer side has seen the request drop. It then raises a completion flag for the host to poll.

Top module: `cfgarb_top`

## Requirements
- R1: After reset the host owns the RAM (`ram_stm_sel`=0), `stm_start`=0, `mem_rvalid`=0, and every register word reads 0.
- R2: While the host owns the RAM, a host write reaches the RAM at word `mem_addr[RAM_AW-1:0]`. A host read returns that word with `mem_rvalid`=1 one clock later.
- R3: Words written at different word offsets are kept apart, and each reads back as written.
- R4: Writing 1 to bit 0 of register word 0 while idle hands the RAM to the streamer at that clock edge. Word 0 bit 0 (busy) and word 1 bit 2 (owner) then read 1. `stm_start` rises after synchronization, and never stands high while the host owns the RAM.
- R5: A host memory write while the streamer owns the RAM is dropped, and the RAM word keeps its earlier value.
- R6: A host memory read while the streamer owns the RAM returns all zeros with `mem_rvalid`=1 one clock later, and sets the sticky denied bit (word 1 bit 1).
- R7: Writing 1 to word 1 bit 1 clears the denied bit. A blocked read in the same clock wins, and the bit stays set.
- R8: Register reads and writes are served while the streamer owns the RAM.
- R9: Once `stm_done` is seen, the busy bit clears. Ownership returns to the host only after `stm_start` and `stm_done` are both low. The completion flag (word 1 bit 0) then reads 1, and it clears on the next start.
- R10: Writing the start bit while a load is active has no effect. After the load returns, the host keeps the RAM and `stm_start` stays low.
- R11: A host memory write in the same clock as the start write still lands in the RAM, because ownership is judged as it stood before that edge.
- R12: While it owns the RAM, the streamer reads word `stm_addr` and sees it on `stm_rdata` one streamer clock later, holding the data the host wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Host-domain reset, active low |
| stm_clk | input | 1 | Streamer clock |
| stm_rst_n | input | 1 | Streamer-domain reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index in the 16-byte range |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` |
| mem_wr | input | 1 | Memory window write strobe |
| mem_rd | input | 1 | Memory window read strobe |
| mem_addr | input | HOST_AW-2 | Word address within the memory window |
| mem_wdata | input | DW | Memory write data |
| mem_rdata | output | DW | Memory read data |
| mem_rvalid | output | 1 | Read data valid, one clock after `mem_rd` |
| stm_start | output | 1 | Load request to the streamer (streamer clock) |
| stm_done | input | 1 | Completion level from the streamer |
| stm_en | input | 1 | Streamer RAM read enable |
| stm_addr | input | RAM_AW | Streamer RAM word address |
| stm_rdata | output | DW | RAM data toward the streamer |
| ram_stm_sel | output | 1 | 1 = streamer owns the RAM and its clock |
| ram_en | output | 1 | RAM enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | RAM_AW | RAM word address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data |

## Verification
Two events can land in the same host clock. A memory write can share a cycle with the start write, and a blocked read can share a cycle with the write-one-to-clear of the denied bit. The bench drives each pair on one edge. For the first pair, it reads the written word back after the load, which shows that ownership was judged before the switch. For the second, it reads the status word, which shows that setting the denied bit takes priority over clearing it. A write of the start bit during the drain phase, after `stm_done` is seen, is judged by watching that the host keeps the RAM once the load ends.

// File: rtl/cfgarb_pkg.sv
`timescale 1ns/1ps
package cfgarb_pkg;

    typedef enum logic [1:0] {
        PH_HOST    = 2'd0,
        PH_LEND    = 2'd1,
        PH_RECLAIM = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   cmpl;
        logic   denied;
    } ctl_s;

    typedef struct packed {
        logic rv;
        logic blk;
    } rsp_s;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;

    localparam int B_BUSY   = 0;
    localparam int B_CMPL   = 0;
    localparam int B_DENIED = 1;
    localparam int B_OWNER  = 2;

endpackage

// File: rtl/cfgarb_sync.sv
`timescale 1ns/1ps
module cfgarb_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/cfgarb_ctrl.sv
`timescale 1ns/1ps
module cfgarb_ctrl
    import cfgarb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_idx,
    input  logic [1:0]    wbits,
    input  logic          deny_pulse,
    input  logic          done_s,
    input  logic          ack_s,
    output logic          req,
    output logic          own_stm,
    output logic [DW-1:0] reg_rdata
);
    ctl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.phase)
            PH_HOST: begin
                if (reg_wr && reg_idx == REG_CTRL && wbits[B_BUSY]) begin
                    ctl_d.phase = PH_LEND;
                    ctl_d.cmpl  = 1'b0;
                end
            end
            PH_LEND: begin
                if (done_s && ack_s) ctl_d.phase = PH_RECLAIM;
            end
            PH_RECLAIM: begin
                if (!done_s && !ack_s) begin
                    ctl_d.phase = PH_HOST;
                    ctl_d.cmpl  = 1'b1;
                end
            end
            default: ctl_d.phase = PH_HOST;
        endcase
        if (deny_pulse) begin
            ctl_d.denied = 1'b1;
        end else if (reg_wr && reg_idx == REG_STAT && wbits[B_DENIED]) begin
            ctl_d.denied = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_HOST, cmpl: 1'b0, denied: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req     = (ctl_q.phase == PH_LEND);
    assign own_stm = (ctl_q.phase != PH_HOST);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_idx)
            REG_CTRL: reg_rdata[B_BUSY] = (ctl_q.phase == PH_LEND);
            REG_STAT: begin
                reg_rdata[B_CMPL]   = ctl_q.cmpl;
                reg_rdata[B_DENIED] = ctl_q.denied;
                reg_rdata[B_OWNER]  = own_stm;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfgarb_mux.sv
`timescale 1ns/1ps
module cfgarb_mux
    import cfgarb_pkg::*;
#(
    parameter int HOST_WAW = 18,
    parameter int RAM_AW   = 10,
    parameter int DW       = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                own_stm,
    input  logic                mem_wr,
    input  logic                mem_rd,
    input  logic [HOST_WAW-1:0] mem_addr,
    input  logic [DW-1:0]       mem_wdata,
    output logic [DW-1:0]       mem_rdata,
    output logic                mem_rvalid,
    input  logic                stm_en,
    input  logic [RAM_AW-1:0]   stm_addr,
    output logic                ram_en,
    output logic                ram_we,
    output logic [RAM_AW-1:0]   ram_addr,
    output logic [DW-1:0]       ram_wdata,
    input  logic [DW-1:0]       ram_rdata,
    output logic                deny_pulse
);
    logic [RAM_AW-1:0] host_word;

    generate
        if (HOST_WAW > RAM_AW) begin : g_alias
            logic unused_hi;
            assign host_word = mem_addr[RAM_AW-1:0];
            assign unused_hi = ^mem_addr[HOST_WAW-1:RAM_AW];
        end else begin : g_full
            assign host_word = RAM_AW'(mem_addr);
        end
    endgenerate

    rsp_s rsp_d, rsp_q;

    always_comb begin
        rsp_d.rv  = mem_rd;
        rsp_d.blk = mem_rd && own_stm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign ram_en     = own_stm ? stm_en : (mem_wr || mem_rd);
    assign ram_we     = !own_stm && mem_wr;
    assign ram_addr   = own_stm ? stm_addr : host_word;
    assign ram_wdata  = mem_wdata;
    assign deny_pulse = rsp_d.blk;
    assign mem_rvalid = rsp_q.rv;
    assign mem_rdata  = rsp_q.blk ? '0 : ram_rdata;
endmodule

// File: rtl/cfgarb_top.sv
`timescale 1ns/1ps
module cfgarb_top #(
    parameter int HOST_AW = 20,
    parameter int RAM_AW  = 10,
    parameter int DW      = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stm_clk,
    input  logic                 stm_rst_n,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    input  logic                 mem_wr,
    input  logic                 mem_rd,
    input  logic [HOST_AW-3:0]   mem_addr,
    input  logic [DW-1:0]        mem_wdata,
    output logic [DW-1:0]        mem_rdata,
    output logic                 mem_rvalid,
    output logic                 stm_start,
    input  logic                 stm_done,
    input  logic                 stm_en,
    input  logic [RAM_AW-1:0]    stm_addr,
    output logic [DW-1:0]        stm_rdata,
    output logic                 ram_stm_sel,
    output logic                 ram_en,
    output logic                 ram_we,
    output logic [RAM_AW-1:0]    ram_addr,
    output logic [DW-1:0]        ram_wdata,
    input  logic [DW-1:0]        ram_rdata
);
    localparam int HOST_WAW = HOST_AW - 2;

    logic req, own_stm, deny_pulse, done_s, ack_s;
    logic unused_wd;

    assign unused_wd = ^reg_wdata[DW-1:2];

    cfgarb_ctrl #(.DW(DW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_idx    (reg_addr),
        .wbits      (reg_wdata[1:0]),
        .deny_pulse (deny_pulse),
        .done_s     (done_s),
        .ack_s      (ack_s),
        .req        (req),
        .own_stm    (own_stm),
        .reg_rdata  (reg_rdata)
    );

    cfgarb_mux #(.HOST_WAW(HOST_WAW), .RAM_AW(RAM_AW), .DW(DW)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .own_stm    (own_stm),
        .mem_wr     (mem_wr),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_rvalid (mem_rvalid),
        .stm_en     (stm_en),
        .stm_addr   (stm_addr),
        .ram_en     (ram_en),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_rdata  (ram_rdata),
        .deny_pulse (deny_pulse)
    );

    cfgarb_sync #(.W(1)) u_req_sync (
        .clk (stm_clk), .rst_n (stm_rst_n), .d (req), .q (stm_start)
    );

    cfgarb_sync #(.W(2)) u_back_sync (
        .clk (clk), .rst_n (rst_n), .d ({stm_start, stm_done}), .q ({ack_s, done_s})
    );

    assign stm_rdata   = ram_rdata;
    assign ram_stm_sel = own_stm;
endmodule

// File: rtl/cfgarb_chk.sv
`timescale 1ns/1ps
module cfgarb_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ram_stm_sel,
    input logic          ram_we,
    input logic          ram_en,
    input logic          mem_wr,
    input logic          mem_rd,
    input logic          mem_rvalid,
    input logic [DW-1:0] mem_rdata,
    input logic          stm_start,
    input logic          reg_wr,
    input logic [1:0]    reg_addr,
    input logic          reg_wd0
);
    p_drop_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_stm_sel |-> !ram_we);

    p_zero_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_rd && ram_stm_sel) |-> (mem_rvalid && mem_rdata == '0));

    p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_stm_sel |-> !stm_start);

    p_handover_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_stm_sel) |-> $past(reg_wr && reg_addr == 2'd0 && reg_wd0));

    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_stm_sel && !mem_wr && !mem_rd) |-> !ram_en);

    p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_rvalid);
endmodule

bind cfgarb_top cfgarb_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ram_stm_sel (ram_stm_sel),
    .ram_we      (ram_we),
    .ram_en      (ram_en),
    .mem_wr      (mem_wr),
    .mem_rd      (mem_rd),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .stm_start   (stm_start),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wd0     (reg_wdata[0])
);

// File: tb/tb_cfgarb_top.sv
`timescale 1ns/1ps
module tb_cfgarb_top;
    localparam int HOST_AW = 20;
    localparam int RAM_AW  = 10;
    localparam int DW      = 32;
    localparam int NV      = 8;
    localparam int NSTM    = 4;

    localparam logic [HOST_AW-3:0] V_ADDR [NV] =
        '{18'd0, 18'd1, 18'd2, 18'd3, 18'd4, 18'd5, 18'd100, 18'd1023};
    localparam logic [DW-1:0] V_DATA [NV] =
        '{32'h1111_0001, 32'h2222_0002, 32'h3333_0003, 32'h4444_0004,
          32'hA5A5_5A5A, 32'h0000_FFFF, 32'hCAFE_0064, 32'hBEEF_03FF};

    logic clk = 1'b0, stm_clk = 1'b0;
    logic rst_n = 1'b0, stm_rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0, reg_rdata;
    logic mem_wr = 1'b0, mem_rd = 1'b0;
    logic [HOST_AW-3:0] mem_addr = '0;
    logic [DW-1:0] mem_wdata = '0, mem_rdata;
    logic mem_rvalid, stm_start;
    logic stm_done = 1'b0, stm_en = 1'b0;
    logic [RAM_AW-1:0] stm_addr = '0;
    logic [DW-1:0] stm_rdata;
    logic ram_stm_sel, ram_en, ram_we;
    logic [RAM_AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic [DW-1:0] ram_rdata = '0;

    logic [DW-1:0] ram_mem [1 << RAM_AW];
    logic [DW-1:0] shadow  [1 << RAM_AW];

    int checks = 0, errors = 0;
    logic let_done = 1'b0, stm_reads_done = 1'b0, finished = 1'b0;

    always #2 clk = ~clk;
    always #3.5 stm_clk = ~stm_clk;

    wire ram_clk = ram_stm_sel ? stm_clk : clk;
    always @(posedge ram_clk) begin
        if (ram_en) begin
            if (ram_we) ram_mem[ram_addr] <= ram_wdata;
            ram_rdata <= ram_mem[ram_addr];
        end
    end

    cfgarb_top #(.HOST_AW(HOST_AW), .RAM_AW(RAM_AW), .DW(DW)) dut (.*);

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] i, input logic [DW-1:0] d);
        reg_wr = 1'b1; reg_addr = i; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] i, output logic [DW-1:0] d);
        reg_addr = i;
        #1;
        d = reg_rdata;
        @(negedge clk);
    endtask

    task automatic mem_write(input logic [HOST_AW-3:0] a, input logic [DW-1:0] d);
        mem_wr = 1'b1; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_wr = 1'b0;
    endtask

    task automatic mem_read(input logic [HOST_AW-3:0] a, output logic v,
                            output logic [DW-1:0] d);
        mem_rd = 1'b1; mem_addr = a;
        @(negedge clk);
        v = mem_rvalid; d = mem_rdata;
        mem_rd = 1'b0;
    endtask

    // Streamer model: reads words 0..NSTM-1 and compares with the host image (R12)
    initial begin
        forever begin
            @(negedge stm_clk);
            if (stm_start && !stm_done) begin
                stm_en = 1'b1; stm_addr = '0;
                for (int i = 0; i < NSTM; i++) begin
                    @(negedge stm_clk);
                    check(stm_rdata == shadow[i], "R12 streamer read", stm_rdata, shadow[i]);
                    stm_addr = RAM_AW'(i + 1);
                end
                stm_en = 1'b0;
                stm_reads_done = 1'b1;
                wait (let_done);
                @(negedge stm_clk);
                stm_done = 1'b1;
                wait (!stm_start);
                @(negedge stm_clk);
                stm_done = 1'b0;
                stm_reads_done = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_return(output int cyc, output bit early);
        cyc = 0; early = 1'b0;
        while (ram_stm_sel && cyc < 500) begin
            @(negedge clk);
            cyc++;
            if (!ram_stm_sel && (stm_done || stm_start)) early = 1'b1;
        end
    endtask

    initial begin
        logic [DW-1:0] d;
        logic v;
        int cyc;
        bit early;
        for (int i = 0; i < (1 << RAM_AW); i++) begin
            ram_mem[i] = '0; shadow[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1; stm_rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(ram_stm_sel == 1'b0, "R1 owner", {31'd0, ram_stm_sel}, 0);
        check(stm_start == 1'b0, "R1 stm_start", {31'd0, stm_start}, 0);
        check(mem_rvalid == 1'b0, "R1 rvalid", {31'd0, mem_rvalid}, 0);
        for (int i = 0; i < 4; i++) begin
            reg_read(2'(i), d);
            check(d == '0, "R1 register", d, 0);
        end

        // R2 R3 vector table: write, then read back
        for (int i = 0; i < NV; i++) begin
            mem_write(V_ADDR[i], V_DATA[i]);
            shadow[V_ADDR[i][RAM_AW-1:0]] = V_DATA[i];
        end
        for (int i = 0; i < NV; i++) begin
            mem_read(V_ADDR[i], v, d);
            check(v == 1'b1, "R2 rvalid", {31'd0, v}, 1);
            check(d == V_DATA[i], "R3 readback", d, V_DATA[i]);
        end

        // R4 + R11: start write together with a memory write
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd1;
        mem_wr = 1'b1; mem_addr = 18'd6; mem_wdata = 32'h0606_6060;
        shadow[6] = 32'h0606_6060;
        @(negedge clk);
        reg_wr = 1'b0; mem_wr = 1'b0;
        check(ram_stm_sel == 1'b1, "R4 handover", {31'd0, ram_stm_sel}, 1);
        reg_read(2'd0, d);
        check(d == 32'd1, "R4 R8 busy", d, 1);
        reg_read(2'd1, d);
        check(d == 32'd4, "R4 R8 owner status", d, 4);

        // R5 blocked write, R6 blocked read
        mem_write(18'd0, 32'hDEAD_DEAD);
        mem_read(18'd1, v, d);
        check(v == 1'b1, "R6 rvalid", {31'd0, v}, 1);
        check(d == '0, "R6 zero data", d, 0);
        reg_read(2'd1, d);
        check(d == 32'd6, "R6 R8 denied set", d, 6);

        // R7 clear and blocked read in the same cycle: set wins
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'd2;
        mem_rd = 1'b1; mem_addr = 18'd2;
        @(negedge clk);
        reg_wr = 1'b0; mem_rd = 1'b0;
        reg_read(2'd1, d);
        check(d == 32'd6, "R7 set beats clear", d, 6);
        reg_write(2'd1, 32'd2);
        reg_read(2'd1, d);
        check(d == 32'd4, "R7 clear", d, 4);

        // R10 start while running
        reg_write(2'd0, 32'd1);
        wait (stm_reads_done);
        @(negedge clk);
        let_done = 1'b1;
        wait (stm_done);
        repeat (4) @(negedge clk);
        reg_write(2'd0, 32'd1);
        reg_read(2'd0, d);
        check(d == 32'd0, "R9 busy cleared after done", d, 0);

        wait_return(cyc, early);
        check(!early, "R9 return only after handshake", {31'd0, early}, 0);
        check(cyc < 500, "R9 ownership returned", cyc, 0);
        reg_read(2'd1, d);
        check(d == 32'd1, "R9 complete flag", d, 1);
        let_done = 1'b0;
        repeat (30) @(negedge clk);
        check(ram_stm_sel == 1'b0, "R10 owner stays host", {31'd0, ram_stm_sel}, 0);
        check(stm_start == 1'b0, "R10 no restart", {31'd0, stm_start}, 0);
        reg_read(2'd0, d);
        check(d == 32'd0, "R10 busy", d, 0);

        mem_read(18'd0, v, d);
        check(d == 32'h1111_0001, "R5 dropped write", d, 32'h1111_0001);
        mem_read(18'd6, v, d);
        check(d == 32'h0606_6060, "R11 same-cycle write", d, 32'h0606_6060);

        // R9 completion flag clears on a new start; second load
        reg_write(2'd0, 32'd1);
        reg_read(2'd1, d);
        check(d == 32'd4, "R9 complete cleared", d, 4);
        wait (stm_reads_done);
        let_done = 1'b1;
        wait_return(cyc, early);
        check(!early && cyc < 500, "R9 second return", cyc, 0);
        let_done = 1'b0;
        repeat (10) @(negedge clk);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule